// File: doc/BRIEF.md
# Cascadable Serial LCD Segment Driver

This block receives display data one bit at a time from a host over a serial clock and data pair, moves it through a 31-stage shift register, and drives 31 static LCD segment lines from a bank of output latches. A load strobe controls the latches. It is level-sensitive and asynchronous. While the strobe is high, the latches follow the shift register. While it is low, the displayed pattern is held no matter what is shifted in. If the strobe is tied high, the block runs in two-wire mode. Each shift then shows on the glass at once, so the host must clock a frame in quickly and then stop the clock.

The bit that leaves the last stage goes out on a serial output. The serial output changes on the falling edge of the serial clock, so a second driver chained after this one samples stable data on its own rising edge. Each segment line is its latched bit XORed with a backplane square wave. A lit segment therefore runs in antiphase with the backplane, and a dark segment runs in phase with it. The backplane comes from one of two sources: an external input, or an internal divider that toggles once every `DIV_HALF` oscillator cycles. The default ratio targets roughly 32 Hz from a 32.768 kHz oscillator.

Top module: `lcd_seg_driver`

## Requirements
- R1: While `rst_ni` is low, the shift register, the output latches, the serial output and the internal backplane divider are all cleared to zero. Right after reset, with the internal backplane selected, `bp_o` is 0 and every segment line is 0.
- R2: On each rising edge of `sclk_i`, stage 0 takes `sdi_i` and stage k takes the old stage k-1. Segment line k (`seg_o[k]`) is fed from stage k. After 31 shifts, the first bit shifted in drives `seg_o[30]`.
- R3: `sdo_o` takes the value of stage 30 on the falling edge of `sclk_i`. Between a rising edge and the next falling edge, it still shows the stage 30 value from before that rising edge.
- R4: While `load_i` is high, the latches follow the shift register continuously, so every shift is visible on the segment lines.
- R5: While `load_i` is low, the segment pattern does not change, however many bits are shifted in.
- R6: A frame shorter than 31 bits is allowed. Shifting M bits moves the earlier contents up by M stages, and a following load pulse shows exactly that result.
- R7: `seg_o[k]` equals latch bit k XOR `bp_o`. A backplane transition with unchanged latches inverts every segment line.
- R8: The internal backplane starts low after reset and toggles once every `DIV_HALF` rising edges of `osc_i`.
- R9: `bp_sel_i` = 1 selects the internal backplane and `bp_sel_i` = 0 selects `bp_ext_i`. `bp_o` carries the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_i | input | 1 | Oscillator clock for the internal backplane divider |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data in, sampled on the rising edge of `sclk_i` |
| load_i | input | 1 | Level-sensitive latch enable, high = transparent |
| bp_ext_i | input | 1 | External backplane square wave |
| bp_sel_i | input | 1 | Backplane source select, 1 = internal, 0 = external |
| sdo_o | output | 1 | Serial data out for cascading, changes on the falling edge of `sclk_i` |
| bp_o | output | 1 | Selected backplane |
| seg_o | output | 31 | Segment lines, each its latched bit XOR backplane |

## Verification
The bench shifts frames with the load strobe low and confirms the display holds the old pattern. A latch that leaked would show the frame walking across the glass. After a load pulse, it checks the bit ordering against the segment index, which catches a reversed shift direction. It samples `sdo_o` both between the rising and falling edges and after the falling edge, so an output timed to the wrong edge is reported. It also covers short frames, two-wire operation with the strobe held high, the backplane period and source select, and segment inversion under an external backplane. A randomized mix of shifts and load-level changes follows the directed cases.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int unsigned SEG_CNT_DEF  = 31;
  localparam int unsigned DIV_HALF_DEF = 512;

  typedef enum logic {
    BP_SRC_EXT = 1'b0,
    BP_SRC_INT = 1'b1
  } bp_src_e;
endpackage

// File: rtl/lcd_shift_chain.sv
module lcd_shift_chain #(
  parameter int unsigned SEG_CNT = 31
) (
  input  logic               sclk_i,
  input  logic               rst_ni,
  input  logic               sdi_i,
  output logic [SEG_CNT-1:0] sh_o,
  output logic               sdo_o
);
  logic [SEG_CNT-1:0] sh_q;
  logic               armed_q;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SEG_CNT-2:0], sdi_i};
  end

  // launch on falling edge so a chained device sees stable data at its rising edge
  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) sdo_o <= 1'b0;
    else         sdo_o <= sh_q[SEG_CNT-1];
  end

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assign sh_o = sh_q;

  AST_SHIFT_ADVANCE: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    armed_q |-> (sh_q == {$past(sh_q[SEG_CNT-2:0]), $past(sdi_i)})); // R2
  AST_SDO_PRE_RISE: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    sdo_o == sh_q[SEG_CNT-1]); // R3
endmodule

// File: rtl/lcd_load_latch.sv
module lcd_load_latch #(
  parameter int unsigned SEG_CNT = 31
) (
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [SEG_CNT-1:0] d_i,
  output logic [SEG_CNT-1:0] q_o
);
  always_latch begin
    if (!rst_ni)     q_o = '0;
    else if (load_i) q_o = d_i;
  end
endmodule

// File: rtl/lcd_bp_gen.sv
module lcd_bp_gen #(
  parameter int unsigned DIV_HALF = 512
) (
  input  logic osc_i,
  input  logic rst_ni,
  output logic bp_o
);
  localparam int unsigned CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             bp_q;
  logic             armed_q;

  always_ff @(posedge osc_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bp_q  <= 1'b0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
      bp_q  <= ~bp_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge osc_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assign bp_o = bp_q;

  AST_BP_TOGGLE_AT_WRAP: assert property (@(posedge osc_i) disable iff (!rst_ni)
    (armed_q && (bp_q != $past(bp_q))) |-> ($past(cnt_q) == CNT_LAST)); // R8
endmodule

// File: rtl/lcd_seg_driver.sv
module lcd_seg_driver
  import lcd_drv_pkg::*;
#(
  parameter int unsigned SEG_CNT  = SEG_CNT_DEF,
  parameter int unsigned DIV_HALF = DIV_HALF_DEF
) (
  input  logic               osc_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sdi_i,
  input  logic               load_i,
  input  logic               bp_ext_i,
  input  logic               bp_sel_i,
  output logic               sdo_o,
  output logic               bp_o,
  output logic [SEG_CNT-1:0] seg_o
);
  logic [SEG_CNT-1:0] sh_w;
  logic [SEG_CNT-1:0] lat_w;
  logic               bp_int_w;
  logic               armed_q;
  bp_src_e            bp_src;

  lcd_shift_chain #(.SEG_CNT(SEG_CNT)) u_chain (
    .sclk_i (sclk_i),
    .rst_ni (rst_ni),
    .sdi_i  (sdi_i),
    .sh_o   (sh_w),
    .sdo_o  (sdo_o)
  );

  lcd_load_latch #(.SEG_CNT(SEG_CNT)) u_latch (
    .rst_ni (rst_ni),
    .load_i (load_i),
    .d_i    (sh_w),
    .q_o    (lat_w)
  );

  lcd_bp_gen #(.DIV_HALF(DIV_HALF)) u_bp (
    .osc_i  (osc_i),
    .rst_ni (rst_ni),
    .bp_o   (bp_int_w)
  );

  assign bp_src = bp_src_e'(bp_sel_i);
  assign bp_o   = (bp_src == BP_SRC_INT) ? bp_int_w : bp_ext_i;

  for (genvar k = 0; k < SEG_CNT; k++) begin : g_seg
    assign seg_o[k] = lat_w[k] ^ bp_o;
  end

  always_ff @(posedge osc_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_LATCH_FOLLOW: assert property (@(posedge osc_i) disable iff (!rst_ni)
    load_i |-> (lat_w == sh_w)); // R4
  AST_LATCH_HOLD: assert property (@(posedge osc_i) disable iff (!rst_ni)
    (armed_q && !load_i && !$past(load_i)) |-> (lat_w == $past(lat_w))); // R5
  AST_BP_FLIP_INVERTS: assert property (@(posedge osc_i) disable iff (!rst_ni)
    (armed_q && (bp_o != $past(bp_o)) && (lat_w == $past(lat_w))) |-> (seg_o == ~$past(seg_o))); // R7
  AST_BP_SOURCE: assert property (@(posedge osc_i) disable iff (!rst_ni)
    (!bp_sel_i) |-> (bp_o == bp_ext_i)); // R9
endmodule

// File: tb/tb_lcd_seg_driver.sv
module tb_lcd_seg_driver;
  localparam int N    = 31;
  localparam int HALF = 8;

  logic osc = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdi = 1'b0, load = 1'b0;
  logic bp_ext = 1'b0, bp_sel = 1'b1;
  logic sdo, bp;
  logic [N-1:0] seg;

  logic [N-1:0] m_sh = '0, m_lat = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 osc = ~osc;

  lcd_seg_driver #(.SEG_CNT(N), .DIV_HALF(HALF)) dut (
    .osc_i(osc), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi), .load_i(load),
    .bp_ext_i(bp_ext), .bp_sel_i(bp_sel), .sdo_o(sdo), .bp_o(bp), .seg_o(seg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_seg(input logic [N-1:0] lat, input logic b);
    return lat ^ {N{b}};
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge osc);
  endtask

  task automatic shift_bit(input logic b);
    logic old_msb;
    old_msb = m_sh[N-1];
    sdi = b;
    tick(1);
    sclk = 1'b1;
    tick(1);
    m_sh = {m_sh[N-2:0], b};
    if (load) m_lat = m_sh;
    chk(sdo == old_msb, "R3 sdo before fall", 32'(sdo), 32'(old_msb));
    sclk = 1'b0;
    tick(1);
    chk(sdo == m_sh[N-1], "R3 sdo after fall", 32'(sdo), 32'(m_sh[N-1]));
  endtask

  task automatic pulse_load();
    load = 1'b1;
    tick(2);
    m_lat = m_sh;
    load = 1'b0;
    tick(1);
  endtask

  task automatic chk_seg(input string req);
    chk(seg == exp_seg(m_lat, bp), req, 32'(seg), 32'(exp_seg(m_lat, bp)));
  endtask

  initial begin
    logic [N-1:0] pat;
    int seed;
    seed = $urandom(32'd4242);
    tick(4);
    rst_n = 1'b1;
    tick(1);
    chk(seg == '0, "R1 seg after reset", 32'(seg), 32'h0);
    chk(sdo == 1'b0, "R1 sdo after reset", 32'(sdo), 32'h0);
    chk(bp == 1'b0, "R1 bp after reset", 32'(bp), 32'h0);

    // R8 internal period, R9 internal selected
    begin
      logic prev;
      int n;
      for (int rep = 0; rep < 2; rep++) begin
        prev = bp; n = 0;
        while (bp == prev && n < 100) begin tick(1); n++; end
        prev = bp; n = 0;
        while (bp == prev && n < 100) begin tick(1); n++; end
        chk(n == HALF, "R8 R9 internal bp half period", 32'(n), 32'(HALF));
      end
    end

    bp_sel = 1'b0; bp_ext = 1'b0;
    tick(1);
    chk(bp == 1'b0, "R9 external bp low", 32'(bp), 32'h0);

    // R5/R2: frame shifted with load low stays invisible, then appears in order
    pat = N'(31'h5A3C_0F96);
    for (int i = N - 1; i >= 0; i--) begin
      shift_bit(pat[i]);
    end
    chk_seg("R5 hold while shifting");
    pulse_load();
    chk(seg == pat, "R2 bit order after load", 32'(seg), 32'(pat));

    // R7 external backplane high inverts
    bp_ext = 1'b1;
    tick(1);
    chk(bp == 1'b1, "R9 external bp high", 32'(bp), 32'h1);
    chk(seg == ~pat, "R7 inverted with bp high", 32'(seg), 32'(~pat));
    bp_ext = 1'b0;
    tick(1);

    // R6 short frame
    for (int i = 0; i < 5; i++) shift_bit(1'(i & 1));
    chk_seg("R6 hold during short frame");
    pulse_load();
    chk_seg("R6 short frame moves contents up");

    // R4 two-wire mode
    load = 1'b1;
    tick(1);
    for (int i = 0; i < 12; i++) begin
      shift_bit(1'($urandom_range(0, 1)));
      chk_seg("R4 transparent tracking");
    end
    load = 1'b0;
    tick(1);

    // random mix, including internal backplane polarity
    for (int it = 0; it < 300; it++) begin
      case ($urandom_range(0, 5))
        0, 1, 2: shift_bit(1'($urandom_range(0, 1)));
        3: pulse_load();
        4: begin load = ~load; if (load) m_lat = m_sh; tick(1); end
        default: begin bp_sel = 1'($urandom_range(0, 1)); bp_ext = 1'($urandom_range(0, 1)); tick(1); end
      endcase
      if (!bp_sel) chk(bp == bp_ext, "R9 select", 32'(bp), 32'(bp_ext));
      chk_seg("R7 R4 R5 random segment pattern");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule